// File: doc/BRIEF.md
# Serial Audio Receive Word Deserializer

This block sits on the receive side of a serial audio port. Running on the bit clock, it samples one serial data bit per rising edge and builds 32-bit receive words from them. A frame sync pulse marks the bit that opens a frame. A frame holds a programmable number of words. The opening word of each frame has its own width, and every later word shares a second width. Each completed word is presented on a 32-bit output together with a one-cycle valid strobe.

Each bit is not packed from the right. It is written into the word at a programmable position. The first bit of every word lands at the start position. The following bits walk one position down when the receiver is in MSB-first order, or one position up in LSB-first order. Positions that receive no bit read as zero.

The configuration inputs are copied into a held set of settings only while the receiver is disabled. Software can therefore prepare new settings at any time, and they take effect at the next enable.

Top module: `audrx_deser`

## Requirements
- R1: While reset is low, and in the first cycle after it, `word_valid` is 0 and `word_data` is all zeros.
- R2: A bit sampled on a rising edge with `rx_enable` and `frame_sync` both high is bit 0 of word 0 of a new frame. Word 0 ends after `lead_width`+1 bits. `word_valid` is high, with `word_data` updated, for exactly the one cycle after the edge that sampled the word's last bit.
- R3: Every word after word 0 in a frame ends after `tail_width`+1 bits.
- R4: With `msb_first`=1, bit k of a word (k=0 first) is stored at position `start_pos`-k.
- R5: With `msb_first`=0, bit k of a word is stored at position `start_pos`+k.
- R6: Bit positions of `word_data` that received no bit of the word are 0.
- R7: A frame holds `last_word`+1 words. After the last one, bits are ignored and no `word_valid` occurs until the next frame sync.
- R8: A frame sync during an unfinished word drops that word with no `word_valid`. The bit sampled with the sync starts word 0 of a new frame.
- R9: The five configuration inputs are captured only on edges where `rx_enable` is low. Changing them while enabled has no effect on the words produced.
- R10: While `rx_enable` is low, no word is received and `word_valid` stays 0. After `rx_enable` rises, bits are ignored until a frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; configuration is captured while low |
| frame_sync | input | 1 | High with the first bit of a frame |
| serial_in | input | 1 | Serial data bit |
| lead_width | input | 5 | Width of word 0 minus one |
| tail_width | input | 5 | Width of later words minus one |
| start_pos | input | 5 | Bit position of each word's first bit |
| msb_first | input | 1 | 1: positions step down; 0: positions step up |
| last_word | input | 5 | Words per frame minus one |
| word_data | output | 32 | Last completed word |
| word_valid | output | 1 | One-cycle strobe for a new word |

## Verification
The bench uses the default 32-bit word and 5-bit word counter. It varies only the run-time settings: unequal lead and tail widths, top and bottom start positions, both bit orders, single-word and multi-word frames, and a lead word narrower than 8 bits. With these settings the bench reaches short frames followed by idle bits, resyncs in the middle of a word, configuration changes made while the receiver is running, and an enable drop in the middle of a frame. Every output is compared on every cycle against a behavioural model.

// File: rtl/audrx_pkg.sv
// Shared sizes and the held configuration record for the serial audio
// receive deserializer. Assumes a power-of-two word size.
package audrx_pkg;
    localparam int unsigned WORD_BITS = 32;
    localparam int unsigned IDX_W     = $clog2(WORD_BITS);
    localparam int unsigned CNT_W     = 5;

    typedef struct packed {
        logic [IDX_W-1:0] lead_width;  // bits in word 0, minus one
        logic [IDX_W-1:0] tail_width;  // bits in later words, minus one
        logic [IDX_W-1:0] start_pos;   // position of each word's first bit
        logic             msb_first;   // 1: positions walk downward
        logic [CNT_W-1:0] last_word;   // words per frame, minus one
    } rx_cfg_t;
endpackage

// File: rtl/audrx_cfg_hold.sv
// Holds the receive configuration. It copies the live inputs on every
// edge where the receiver is disabled and freezes them while enabled.
// Assumes the inputs are stable in the cycle before enable rises.
module audrx_cfg_hold
    import audrx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  rx_cfg_t cfg_in,
    output rx_cfg_t cfg_q
);
    // Capture settings only while disabled; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!enable) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/audrx_seq.sv
// Frame sequencer. It counts bits within a word and words within a frame,
// starts a frame on a sync, stops after the last word and goes idle while
// disabled. It assumes the settings are held for as long as it is enabled.
module audrx_seq
    import audrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fsync,
    input  rx_cfg_t          cfg,
    output logic             take,
    output logic             word_start,
    output logic             word_end,
    output logic [CNT_W-1:0] word_idx
);
    logic             active_q;
    logic [IDX_W-1:0] bit_q;
    logic [CNT_W-1:0] word_q;
    logic             start;
    logic [IDX_W-1:0] cur_bit;
    logic [CNT_W-1:0] cur_word;
    logic [IDX_W-1:0] width_now;

    // Decide whether this bit is taken and where it falls in its word.
    always_comb begin
        start      = enable & fsync;
        take       = enable & (fsync | active_q);
        cur_bit    = start ? '0 : bit_q;
        cur_word   = start ? '0 : word_q;
        width_now  = (cur_word == '0) ? cfg.lead_width : cfg.tail_width;
        word_start = take & (cur_bit == '0);
        word_end   = take & (cur_bit == width_now);
    end

    assign word_idx = word_q;

    // Advance the bit and word counters; stop after the frame's last word.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            active_q <= 1'b0;
            bit_q    <= '0;
            word_q   <= '0;
        end else if (take) begin
            if (word_end) begin
                bit_q <= '0;
                if (cur_word == cfg.last_word) begin
                    active_q <= 1'b0;
                    word_q   <= cur_word;
                end else begin
                    active_q <= 1'b1;
                    word_q   <= cur_word + 1'b1;
                end
            end else begin
                active_q <= 1'b1;
                bit_q    <= cur_bit + 1'b1;
                word_q   <= cur_word;
            end
        end
    end
endmodule

// File: rtl/audrx_pack.sv
// Word assembler. It places each taken bit at a walking position, starts
// each word from zeros, and registers the finished word with a one-cycle
// strobe. It assumes take/start/end come from the sequencer in the same cycle.
module audrx_pack
    import audrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sdata,
    input  logic                 take,
    input  logic                 word_start,
    input  logic                 word_end,
    input  logic [IDX_W-1:0]     start_pos,
    input  logic                 msb_first,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_valid
);
    logic [WORD_BITS-1:0] acc_q;
    logic [IDX_W-1:0]     pos_q;
    logic [IDX_W-1:0]     pos;
    logic [WORD_BITS-1:0] base;
    logic [WORD_BITS-1:0] merged;
    logic [IDX_W-1:0]     pos_next;

    // Merge the current bit into the partial word at its position.
    always_comb begin
        pos      = word_start ? start_pos : pos_q;
        base     = word_start ? '0 : acc_q;
        merged   = base | (WORD_BITS'(sdata) << pos);
        pos_next = msb_first ? (pos - 1'b1) : (pos + 1'b1);
    end

    // Keep the partial word and publish it when its last bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            pos_q      <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= word_end;
            if (take) begin
                acc_q <= merged;
                pos_q <= pos_next;
                if (word_end) begin
                    word_data <= merged;
                end
            end
        end
    end
endmodule

// File: rtl/audrx_deser.sv
// Top level of the serial audio receive word deserializer. It holds the
// configuration, sequences frames and assembles words. One bit per clk.
module audrx_deser
    import audrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_enable,
    input  logic                 frame_sync,
    input  logic                 serial_in,
    input  logic [IDX_W-1:0]     lead_width,
    input  logic [IDX_W-1:0]     tail_width,
    input  logic [IDX_W-1:0]     start_pos,
    input  logic                 msb_first,
    input  logic [CNT_W-1:0]     last_word,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_valid
);
    rx_cfg_t          cfg_live;
    rx_cfg_t          cfg_q;
    logic             take;
    logic             word_start;
    logic             word_end;
    logic [CNT_W-1:0] word_cnt;

    // Gather the loose configuration pins into one record.
    always_comb begin
        cfg_live.lead_width = lead_width;
        cfg_live.tail_width = tail_width;
        cfg_live.start_pos  = start_pos;
        cfg_live.msb_first  = msb_first;
        cfg_live.last_word  = last_word;
    end

    audrx_cfg_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rx_enable),
        .cfg_in (cfg_live),
        .cfg_q  (cfg_q)
    );

    audrx_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_enable),
        .fsync      (frame_sync),
        .cfg        (cfg_q),
        .take       (take),
        .word_start (word_start),
        .word_end   (word_end),
        .word_idx   (word_cnt)
    );

    audrx_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdata      (serial_in),
        .take       (take),
        .word_start (word_start),
        .word_end   (word_end),
        .start_pos  (cfg_q.start_pos),
        .msb_first  (cfg_q.msb_first),
        .word_data  (word_data),
        .word_valid (word_valid)
    );
endmodule

// File: rtl/audrx_deser_chk.sv
// Property checker for audrx_deser. It is bound to every instance and
// watches the ports plus the held settings and the word counter.
module audrx_deser_chk
    import audrx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_enable,
    input logic                 frame_sync,
    input logic                 word_valid,
    input logic [WORD_BITS-1:0] word_data,
    input rx_cfg_t              cfg_q,
    input logic [CNT_W-1:0]     word_cnt
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!word_valid && word_data == '0)); // R1

    AST_SYNC_BIT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && frame_sync && cfg_q.lead_width != '0) |=> !word_valid); // R8

    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |-> (word_cnt <= cfg_q.last_word)); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |=> $stable(cfg_q)); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !word_valid); // R10
endmodule

bind audrx_deser audrx_deser_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_enable  (rx_enable),
    .frame_sync (frame_sync),
    .word_valid (word_valid),
    .word_data  (word_data),
    .cfg_q      (cfg_q),
    .word_cnt   (word_cnt)
);

// File: tb/audrx_deser_test.sv
module audrx_deser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        frame_sync = 1'b0;
    logic        serial_in = 1'b0;
    logic [4:0]  lead_width = '0;
    logic [4:0]  tail_width = '0;
    logic [4:0]  start_pos = '0;
    logic        msb_first = 1'b0;
    logic [4:0]  last_word = '0;
    logic [31:0] word_data;
    logic        word_valid;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int          m_lw, m_tw, m_sp, m_msb, m_last;
    int          m_active, m_bit, m_word, m_pos;
    logic [31:0] m_acc;
    logic        exp_v = 1'b0;
    logic [31:0] exp_d = '0;

    always #10 clk = ~clk;

    audrx_deser uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .frame_sync(frame_sync),
        .serial_in(serial_in), .lead_width(lead_width), .tail_width(tail_width),
        .start_pos(start_pos), .msb_first(msb_first), .last_word(last_word),
        .word_data(word_data), .word_valid(word_valid)
    );

    // Reference model: steps once per rising edge from the requirements.
    always @(posedge clk) begin
        int w;
        if (!rst_n) begin
            exp_v = 1'b0; exp_d = '0;
            m_lw = 0; m_tw = 0; m_sp = 0; m_msb = 0; m_last = 0;
            m_active = 0; m_bit = 0; m_word = 0; m_pos = 0; m_acc = '0;
        end else begin
            exp_v = 1'b0;
            if (!rx_enable) begin
                m_lw = lead_width; m_tw = tail_width; m_sp = start_pos;
                m_msb = msb_first; m_last = last_word;
                m_active = 0; m_bit = 0; m_word = 0;
            end else if (frame_sync || m_active != 0) begin
                if (frame_sync) begin
                    m_active = 1; m_word = 0; m_bit = 0;
                end
                if (m_bit == 0) begin
                    m_acc = '0; m_pos = m_sp;
                end
                m_acc[m_pos] = serial_in;
                m_pos = (m_msb != 0) ? ((m_pos + 31) % 32) : ((m_pos + 1) % 32);
                w = (m_word == 0) ? m_lw : m_tw;
                if (m_bit == w) begin
                    exp_v = 1'b1; exp_d = m_acc; m_bit = 0;
                    if (m_word == m_last) m_active = 0;
                    else m_word = m_word + 1;
                end else begin
                    m_bit = m_bit + 1;
                end
            end
        end
    end

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        checks++;
        if (word_valid !== exp_v || word_data !== exp_d) begin
            fails++;
            $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
                     cur_req, word_valid, word_data, exp_v, exp_d);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 60000", cycles);
            summary();
            $finish;
        end
    end

    task automatic drive(input logic fs, input logic sd);
        @(negedge clk);
        frame_sync = fs;
        serial_in  = sd;
    endtask

    task automatic set_cfg(input int lw, input int tw, input int sp, input int msb, input int lst);
        @(negedge clk);
        rx_enable = 1'b0; frame_sync = 1'b0;
        lead_width = 5'(lw); tail_width = 5'(tw); start_pos = 5'(sp);
        msb_first = msb[0]; last_word = 5'(lst);
        @(negedge clk);
        rx_enable = 1'b1;
    endtask

    task automatic send_frame(input int nbits);
        for (int i = 0; i < nbits; i++) drive(i == 0, 1'($urandom));
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'($urandom));
    endtask

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R2";   // 16-bit lead word, MSB-first from position 31
        set_cfg(15, 23, 31, 1, 2);
        send_frame(16 + 24 + 24);
        cur_req = "R3";
        send_frame(16 + 24 + 24);
        cur_req = "R4";
        send_frame(16 + 24 + 24);
        idle_bits(4);

        cur_req = "R5";   // LSB-first from position 2, 8-bit lead, 12-bit tail
        set_cfg(7, 11, 2, 0, 1);
        send_frame(8 + 12);
        send_frame(8 + 12);
        cur_req = "R7";
        idle_bits(30);
        send_frame(8 + 12);
        idle_bits(15);

        cur_req = "R6";   // single 8-bit word placed at 20..13
        set_cfg(7, 7, 20, 1, 0);
        for (int i = 0; i < 8; i++) drive(i == 0, 1'b1);
        idle_bits(3);
        checks++;
        if (word_data !== 32'h001F_E000) begin
            fails++;
            $display("FAIL R6: data=%h expected %h", word_data, 32'h001F_E000);
        end
        set_cfg(3, 9, 9, 1, 3);   // 4-bit lead word with several words
        send_frame(4 + 30);
        send_frame(4 + 30 + 10);

        cur_req = "R8";   // resync inside lead and tail words
        set_cfg(11, 15, 15, 1, 2);
        send_frame(5);
        send_frame(12 + 7);
        send_frame(12 + 16 + 16);
        idle_bits(5);

        cur_req = "R9";   // live inputs change mid-frame
        set_cfg(9, 13, 0, 0, 2);
        drive(1'b1, 1'($urandom));
        idle_bits(6);
        lead_width = 5'd20; tail_width = 5'd7; start_pos = 5'd31;
        msb_first = 1'b1; last_word = 5'd0;
        idle_bits(3 + 14 + 14 + 6);
        send_frame(10 + 14 + 14);
        idle_bits(4);

        cur_req = "R10";  // enable drop mid-frame, then no sync
        set_cfg(7, 15, 16, 1, 3);
        send_frame(8 + 5);
        @(negedge clk); rx_enable = 1'b0;
        idle_bits(3);
        @(negedge clk); rx_enable = 1'b1;
        idle_bits(40);
        send_frame(8 + 16 + 16 + 16);
        idle_bits(4);

        summary();
        $finish;
    end
endmodule